// File: doc/BRIEF.md
# Register File with Pointer Addressing

This block holds 32 general-purpose 8-bit registers for a small processor datapath. Two operand ports read bytes, a byte port writes a result, and a pair port writes a 16-bit result to two adjacent registers. A third read port returns one register pair as a 16-bit operand. All of these ports can work in the same cycle.

The top six registers also serve, two at a time, as three 16-bit pointers. Pointer 0 is held in registers 27:26, pointer 1 in 29:28 and pointer 2 in 31:30. An access stage takes either a direct 16-bit address or a selected pointer. The pointer can be used as it is, used and then stepped up, or stepped down and then used. The access stage writes the updated pointer back into its pair. It also sorts the effective address into one of four regions: register window, I/O window, SRAM window, or none of them.

Register-window hits load from and store into the file itself. I/O and SRAM hits are only flagged for the logic outside this block.

Top module: `gpr_file_top`

## Requirements
- R1: A synchronous reset clears every register and every registered output to zero.
- R2: Each read port gives, one clock after the index is presented, the register value as it stood before that edge. A write at the same edge is not yet visible.
- R3: A byte write stores `wr_data` into register `wr_idx` at the clock edge.
- R4: A pair write ignores bit 0 of `pw_idx`. It stores `pw_data[7:0]` into the even register and `pw_data[15:8]` into the odd register. It can run in the same cycle as a byte write to another pair.
- R5: The pair read port ignores bit 0 of `rd_p_idx`. One clock later it returns {odd register, even register}.
- R6: `acc_sel` picks the pointer: 0 for registers 27:26, 1 for 29:28, 2 for 31:30, and 3 acts as 2. The odd register is the high byte.
- R7: `acc_mode` 0 (plain) and 3 use the pointer value as the effective address and leave the pointer unchanged.
- R8: `acc_mode` 1 (post-increment) uses the current pointer value as the effective address. It then writes back pointer+1, wrapping modulo 2^16.
- R9: `acc_mode` 2 (pre-decrement) writes back pointer-1, wrapping modulo 2^16, and uses that new value as the effective address.
- R10: One clock after `acc_en`, `acc_ea` shows the effective address and exactly one region flag is set:
  - register for 0x0000–0x001F;
  - I/O for 0x0020–0x005F;
  - SRAM for 0x0060–0x045F;
  - no flag at or above 0x0460.
  
  With `acc_en` low, all flags and `acc_rdata` read zero one clock later.
- R11: A register-window access loads the register at the low five address bits into `acc_rdata`, taking the value before the edge. With `acc_we` it also stores `acc_wdata` there. Accesses outside that window return zero and change no register.
- R12: When writes collide on one register, the pointer write-back wins first, then the register-window store, then the pair write, then the byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data, registered |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data, registered |
| rd_p_idx | input | 5 | Pair read index, bit 0 ignored |
| rd_p_data | output | 16 | Pair read data {odd, even}, registered |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pw_en | input | 1 | Pair write enable |
| pw_idx | input | 5 | Pair write index, bit 0 ignored |
| pw_data | input | 16 | Pair write data, low byte to even register |
| acc_en | input | 1 | Data access request |
| acc_we | input | 1 | Access is a store |
| acc_ptr | input | 1 | Use a pointer instead of acc_addr |
| acc_sel | input | 2 | Pointer select |
| acc_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 plain |
| acc_addr | input | 16 | Direct address when acc_ptr is low |
| acc_wdata | input | 8 | Store data |
| acc_ea | output | 16 | Effective address of the last access |
| acc_hit_reg | output | 1 | Last access fell in the register window |
| acc_hit_io | output | 1 | Last access fell in the I/O window |
| acc_hit_sram | output | 1 | Last access fell in the SRAM window |
| acc_rdata | output | 8 | Load data for register-window hits, else zero |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, a 64-entry I/O window and 1024 bytes of SRAM. With this size the bench can write and read back every register through every port and every pair. It can also sweep each direct address from 0x0000 to 0x04FF, which covers all three region boundaries.

Pointer values of 0x0000 and 0xFFFF exercise both wrap directions of the 16-bit pointer arithmetic. A pointer aimed into the register window exercises self-referencing stores and loads. Constructed collisions exercise every level of the write priority.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_SPARE   = 2'd3
  } addr_mode_e;

  typedef struct packed {
    logic reg_hit;
    logic io_hit;
    logic sram_hit;
  } region_t;
endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr_cur,
  input  logic [1:0]    mode,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_next,
  output logic          wb
);
  always_comb begin
    unique case (addr_mode_e'(mode))
      AM_POSTINC: begin
        ptr_next = ptr_cur + AW'(1);
        ea       = ptr_cur;
        wb       = 1'b1;
      end
      AM_PREDEC: begin
        ptr_next = ptr_cur - AW'(1);
        ea       = ptr_cur - AW'(1);
        wb       = 1'b1;
      end
      default: begin
        ptr_next = ptr_cur;
        ea       = ptr_cur;
        wb       = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/gpr_addr_decode.sv
module gpr_addr_decode
  import gpr_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned NREG       = 32,
  parameter int unsigned IO_COUNT   = 64,
  parameter int unsigned SRAM_BYTES = 1024
) (
  input  logic [AW-1:0] addr,
  output region_t       region
);
  localparam int unsigned IO_LO    = NREG;
  localparam int unsigned SRAM_LO  = NREG + IO_COUNT;
  localparam int unsigned SRAM_END = SRAM_LO + SRAM_BYTES;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    region.reg_hit  = (a32 < IO_LO);
    region.io_hit   = (a32 >= IO_LO) && (a32 < SRAM_LO);
    region.sram_hit = (a32 >= SRAM_LO) && (a32 < SRAM_END);
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            w8_en,
  input  logic [IW-1:0]   w8_idx,
  input  logic [DW-1:0]   w8_data,
  input  logic            p_en,
  input  logic [IW-1:0]   p_idx,
  input  logic [2*DW-1:0] p_data,
  input  logic            m_en,
  input  logic [IW-1:0]   m_idx,
  input  logic [DW-1:0]   m_data,
  input  logic            q_en,
  input  logic [IW-1:0]   q_idx,
  input  logic [2*DW-1:0] q_data,
  output logic [DW-1:0]   regs [NREG]
);
  logic [DW-1:0] nxt [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    localparam logic [IW-1:0] MY  = IW'(i);
    localparam bit            ODD = (i % 2) == 1;
    logic q_hit, m_hit, p_hit, w_hit;
    logic [DW-1:0] q_byte, p_byte;
    assign q_hit  = q_en && ((q_idx >> 1) == (MY >> 1));
    assign m_hit  = m_en && (m_idx == MY);
    assign p_hit  = p_en && ((p_idx >> 1) == (MY >> 1));
    assign w_hit  = w8_en && (w8_idx == MY);
    assign q_byte = ODD ? q_data[2*DW-1:DW] : q_data[DW-1:0];
    assign p_byte = ODD ? p_data[2*DW-1:DW] : p_data[DW-1:0];
    assign nxt[i] = q_hit ? q_byte :
                    m_hit ? m_data :
                    p_hit ? p_byte :
                    w_hit ? w8_data : regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) regs <= '{default: '0};
    else     regs <= nxt;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (regs[0] == '0 && regs[NREG-1] == '0 && regs[NREG-6] == '0)); // R1

  AST_BYTE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (w8_en && !(q_en && (q_idx >> 1) == (w8_idx >> 1))
           && !(m_en && m_idx == w8_idx)
           && !(p_en && (p_idx >> 1) == (w8_idx >> 1)))
    |=> regs[$past(w8_idx)] == $past(w8_data)); // R3

  AST_PAIR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (p_en && !(q_en && (q_idx >> 1) == (p_idx >> 1))
          && !(m_en && (m_idx >> 1) == (p_idx >> 1)))
    |=> {regs[$past(p_idx) | IW'(1)], regs[$past(p_idx) & ~IW'(1)]} == $past(p_data)); // R4

  AST_PTR_WINS: assert property (@(posedge clk) disable iff (rst)
    q_en |=> {regs[$past(q_idx) | IW'(1)], regs[$past(q_idx) & ~IW'(1)]} == $past(q_data)); // R12
endmodule

// File: rtl/gpr_file_top.sv
module gpr_file_top
  import gpr_pkg::*;
#(
  parameter int unsigned NREG       = 32,
  parameter int unsigned DW         = 8,
  parameter int unsigned IO_COUNT   = 64,
  parameter int unsigned SRAM_BYTES = 1024
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NREG)-1:0]   rd_a_idx,
  output logic [DW-1:0]             rd_a_data,
  input  logic [$clog2(NREG)-1:0]   rd_b_idx,
  output logic [DW-1:0]             rd_b_data,
  input  logic [$clog2(NREG)-1:0]   rd_p_idx,
  output logic [2*DW-1:0]           rd_p_data,
  input  logic                      wr_en,
  input  logic [$clog2(NREG)-1:0]   wr_idx,
  input  logic [DW-1:0]             wr_data,
  input  logic                      pw_en,
  input  logic [$clog2(NREG)-1:0]   pw_idx,
  input  logic [2*DW-1:0]           pw_data,
  input  logic                      acc_en,
  input  logic                      acc_we,
  input  logic                      acc_ptr,
  input  logic [1:0]                acc_sel,
  input  logic [1:0]                acc_mode,
  input  logic [2*DW-1:0]           acc_addr,
  input  logic [DW-1:0]             acc_wdata,
  output logic [2*DW-1:0]           acc_ea,
  output logic                      acc_hit_reg,
  output logic                      acc_hit_io,
  output logic                      acc_hit_sram,
  output logic [DW-1:0]             acc_rdata
);
  localparam int unsigned IW       = $clog2(NREG);
  localparam int unsigned AW       = 2 * DW;
  localparam int unsigned PTR_BASE = NREG - 6;

  logic [DW-1:0] regs [NREG];
  logic [1:0]    sel_eff;
  logic [IW-1:0] ptr_lo;
  logic [AW-1:0] cur_ptr, ptr_ea, ptr_next, ea;
  logic          ptr_wb;
  region_t       region;

  assign sel_eff = (acc_sel == 2'd3) ? 2'd2 : acc_sel;
  assign ptr_lo  = IW'(PTR_BASE) + IW'({sel_eff, 1'b0});
  assign cur_ptr = {regs[ptr_lo | IW'(1)], regs[ptr_lo]};

  gpr_ptr_unit #(.AW(AW)) u_ptr (
    .ptr_cur (cur_ptr),
    .mode    (acc_mode),
    .ea      (ptr_ea),
    .ptr_next(ptr_next),
    .wb      (ptr_wb)
  );

  assign ea = acc_ptr ? ptr_ea : acc_addr;

  gpr_addr_decode #(
    .AW(AW), .NREG(NREG), .IO_COUNT(IO_COUNT), .SRAM_BYTES(SRAM_BYTES)
  ) u_dec (
    .addr  (ea),
    .region(region)
  );

  gpr_store #(.NREG(NREG), .DW(DW), .IW(IW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .w8_en  (wr_en),
    .w8_idx (wr_idx),
    .w8_data(wr_data),
    .p_en   (pw_en),
    .p_idx  (pw_idx),
    .p_data (pw_data),
    .m_en   (acc_en && acc_we && region.reg_hit),
    .m_idx  (ea[IW-1:0]),
    .m_data (acc_wdata),
    .q_en   (acc_en && acc_ptr && ptr_wb),
    .q_idx  (ptr_lo),
    .q_data (ptr_next),
    .regs   (regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data    <= '0;
      rd_b_data    <= '0;
      rd_p_data    <= '0;
      acc_ea       <= '0;
      acc_hit_reg  <= 1'b0;
      acc_hit_io   <= 1'b0;
      acc_hit_sram <= 1'b0;
      acc_rdata    <= '0;
    end else begin
      rd_a_data    <= regs[rd_a_idx];
      rd_b_data    <= regs[rd_b_idx];
      rd_p_data    <= {regs[rd_p_idx | IW'(1)], regs[rd_p_idx & ~IW'(1)]};
      if (acc_en) acc_ea <= ea;
      acc_hit_reg  <= acc_en && region.reg_hit;
      acc_hit_io   <= acc_en && region.io_hit;
      acc_hit_sram <= acc_en && region.sram_hit;
      acc_rdata    <= (acc_en && region.reg_hit) ? regs[ea[IW-1:0]] : '0;
    end
  end

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_hit_reg, acc_hit_io, acc_hit_sram})); // R10

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!acc_hit_reg && !acc_hit_io && !acc_hit_sram && acc_rdata == '0)); // R10

  AST_POSTINC_EA: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_ptr && acc_mode == 2'd1) |=> acc_ea == $past(cur_ptr)); // R8

  AST_POSTINC_WB: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_ptr && acc_mode == 2'd1)
    |=> {regs[$past(ptr_lo) | IW'(1)], regs[$past(ptr_lo)]} == $past(cur_ptr) + AW'(1)); // R8

  AST_PREDEC_EA: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_ptr && acc_mode == 2'd2) |=> acc_ea == $past(cur_ptr) - AW'(1)); // R9
endmodule

// File: tb/gpr_file_top_bench.sv
module gpr_file_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, rd_p_idx, wr_idx, pw_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, acc_wdata, acc_rdata;
  logic [15:0] rd_p_data, pw_data, acc_addr, acc_ea;
  logic        wr_en, pw_en, acc_en, acc_we, acc_ptr;
  logic [1:0]  acc_sel, acc_mode;
  logic        acc_hit_reg, acc_hit_io, acc_hit_sram;

  always #10 clk = ~clk;

  gpr_file_top u_gpr_file_top (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rd_p_idx(rd_p_idx), .rd_p_data(rd_p_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
    .acc_en(acc_en), .acc_we(acc_we), .acc_ptr(acc_ptr), .acc_sel(acc_sel),
    .acc_mode(acc_mode), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ea(acc_ea), .acc_hit_reg(acc_hit_reg), .acc_hit_io(acc_hit_io),
    .acc_hit_sram(acc_hit_sram), .acc_rdata(acc_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] mdl [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; pw_en = 0; acc_en = 0; acc_we = 0; acc_ptr = 0;
    acc_sel = 0; acc_mode = 0; acc_addr = 0; acc_wdata = 0;
    wr_idx = 0; wr_data = 0; pw_idx = 0; pw_data = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [2:0] flags_of(input logic [15:0] a);
    if (a < 16'h0020)      return 3'b100;
    else if (a < 16'h0060) return 3'b010;
    else if (a < 16'h0460) return 3'b001;
    else                   return 3'b000;
  endfunction

  task automatic check_access(input string req, input logic [15:0] ea_exp, input logic [7:0] rd_exp);
    chk(req, acc_ea, ea_exp);
    chk("R10 flags", {acc_hit_reg, acc_hit_io, acc_hit_sram}, flags_of(ea_exp));
    chk("R11 load", acc_rdata, rd_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h001F, 16'h0060, 16'h1234, 16'hFFFF};
    quiet();
    rd_a_idx = 0; rd_b_idx = 0; rd_p_idx = 0;
    rst = 1;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs after reset
    chk("R1 rd_a", rd_a_data, 0);
    chk("R1 rd_p", rd_p_data, 0);
    chk("R1 flags", {acc_hit_reg, acc_hit_io, acc_hit_sram, acc_rdata}, 0);
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r);
      tick();
      chk("R1 reg A", rd_a_data, 0);
      chk("R1 reg B", rd_b_data, 0);
    end

    // R2/R3: byte writes with read-before-write
    for (int r = 0; r < 32; r++) begin
      logic [7:0] ea_exp, eb_exp;
      wr_en = 1; wr_idx = 5'(r); wr_data = 8'(r * 37 + 5);
      rd_a_idx = 5'(r); rd_b_idx = 5'((r + 31) % 32);
      ea_exp = mdl[r]; eb_exp = mdl[(r + 31) % 32];
      tick();
      chk("R2 old value", rd_a_data, ea_exp);
      chk("R3 prior write", rd_b_data, eb_exp);
      mdl[r] = 8'(r * 37 + 5);
    end
    quiet();
    for (int r = 0; r < 32; r++) begin
      rd_b_idx = 5'(r);
      tick();
      chk("R3 readback", rd_b_data, mdl[r]);
    end

    // R4/R5: pair writes with concurrent byte writes, odd index given
    for (int k = 0; k < 16; k++) begin
      int w;
      w = (2 * k + 5) % 32;
      pw_en = 1; pw_idx = 5'(2 * k + 1); pw_data = 16'(k * 4951 + 9320);
      wr_en = 1; wr_idx = 5'(w); wr_data = 8'(k * 11 + 160);
      tick();
      mdl[2 * k]     = pw_data[7:0];
      mdl[2 * k + 1] = pw_data[15:8];
      mdl[w]         = wr_data;
    end
    quiet();
    for (int k = 0; k < 16; k++) begin
      rd_p_idx = 5'(2 * k + 1);
      tick();
      chk("R5 pair read", rd_p_data, {mdl[2 * k + 1], mdl[2 * k]});
    end

    // R6-R9: pointer modes over all selects and wrap values
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 6; v++) begin
        for (int m = 0; m < 4; m++) begin
          int lo;
          logic [15:0] pv, ea_exp, nx;
          logic [7:0] rd_exp;
          lo = 26 + 2 * ((s == 3) ? 2 : s);
          pv = vals[v];
          quiet();
          pw_en = 1; pw_idx = 5'(lo); pw_data = pv;
          tick();
          mdl[lo] = pv[7:0]; mdl[lo + 1] = pv[15:8];
          quiet();
          acc_en = 1; acc_ptr = 1; acc_sel = 2'(s); acc_mode = 2'(m); acc_addr = 16'h0BAD;
          ea_exp = (m == 2) ? pv - 16'd1 : pv;
          nx     = (m == 1) ? pv + 16'd1 : (m == 2) ? pv - 16'd1 : pv;
          rd_exp = (ea_exp < 16'h0020) ? mdl[ea_exp[4:0]] : 8'h00;
          tick();
          case (m)
            1:       check_access("R8 post-inc ea", ea_exp, rd_exp);
            2:       check_access("R9 pre-dec ea", ea_exp, rd_exp);
            default: check_access("R7 plain ea", ea_exp, rd_exp);
          endcase
          mdl[lo] = nx[7:0]; mdl[lo + 1] = nx[15:8];
          quiet();
          rd_p_idx = 5'(lo);
          tick();
          chk("R6 pointer writeback", rd_p_data, nx);
        end
      end
    end

    // R10: direct address sweep across all region boundaries
    for (int a = 0; a <= 32'h500; a++) begin
      logic [15:0] aa;
      aa = (a == 32'h500) ? 16'hFFFF : 16'(a);
      quiet();
      acc_en = 1; acc_addr = aa;
      tick();
      check_access("R10 direct ea", aa, (aa < 16'h0020) ? mdl[aa[4:0]] : 8'h00);
    end
    quiet();
    tick();
    chk("R10 idle flags", {acc_hit_reg, acc_hit_io, acc_hit_sram, acc_rdata}, 0);

    // R11: register-window stores, and stores outside it that must not land
    for (int r = 0; r < 32; r++) begin
      logic [7:0] old;
      quiet();
      acc_en = 1; acc_we = 1; acc_addr = 16'(r); acc_wdata = 8'(r * 91 + 3);
      old = mdl[r];
      tick();
      chk("R11 store old load", acc_rdata, old);
      mdl[r] = 8'(r * 91 + 3);
    end
    for (int r = 0; r < 32; r++) begin
      quiet();
      acc_en = 1; acc_we = 1; acc_addr = 16'(32'h20 + r); acc_wdata = 8'hEE;
      tick();
      chk("R11 io store no load", acc_rdata, 0);
      quiet();
      acc_en = 1; acc_we = 1; acc_addr = 16'(32'h460 + r); acc_wdata = 8'hEE;
      tick();
      chk("R11 far store no load", acc_rdata, 0);
    end
    quiet();
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r);
      tick();
      chk("R11 file contents", rd_a_data, mdl[r]);
    end

    // R12: pointer beats store, pair and byte on the pointer pair
    quiet(); pw_en = 1; pw_idx = 5'd26; pw_data = 16'h0010; tick();
    quiet();
    acc_en = 1; acc_ptr = 1; acc_sel = 0; acc_mode = 1; acc_we = 1; acc_wdata = 8'h5A;
    wr_en = 1; wr_idx = 5'd26; wr_data = 8'h77;
    pw_en = 1; pw_idx = 5'd26; pw_data = 16'hABCD;
    tick();
    chk("R12 ea", acc_ea, 16'h0010);
    quiet(); rd_p_idx = 5'd26; rd_a_idx = 5'd16; tick();
    chk("R12 pointer wins", rd_p_data, 16'h0011);
    chk("R12 store via pointer", rd_a_data, 8'h5A);
    // R12: store beats pair, pair beats byte
    quiet();
    acc_en = 1; acc_we = 1; acc_addr = 16'h0004; acc_wdata = 8'h3C;
    pw_en = 1; pw_idx = 5'd4; pw_data = 16'hBBCC;
    wr_en = 1; wr_idx = 5'd5; wr_data = 8'hDD;
    tick();
    quiet(); rd_p_idx = 5'd4; tick();
    chk("R12 store over pair", rd_p_data, 16'hBB3C);
    quiet();
    pw_en = 1; pw_idx = 5'd8; pw_data = 16'h1122;
    wr_en = 1; wr_idx = 5'd9; wr_data = 8'h77;
    tick();
    quiet(); rd_p_idx = 5'd8; tick();
    chk("R12 pair over byte", rd_p_data, 16'h1122);
    // R12: store through a pointer that addresses its own low byte
    quiet(); pw_en = 1; pw_idx = 5'd26; pw_data = 16'h001A; tick();
    quiet();
    acc_en = 1; acc_ptr = 1; acc_sel = 0; acc_mode = 1; acc_we = 1; acc_wdata = 8'h99;
    tick();
    quiet(); rd_p_idx = 5'd26; tick();
    chk("R12 self store", rd_p_data, 16'h001B);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule